// File: doc/BRIEF.md
# Shared-ALU Multicycle Processor Datapath

This block is a small processor core in which every data movement funnels through a single arithmetic unit. It has one register bank with two read ports and one write port. The first read port drives the A operand bus and the second drives the B operand bus. The write port takes the ALU result. The same result can instead be captured by a memory address register, which drives the external memory address. The program counter is an ordinary member of the register bank, and the main ALU advances it during every fetch. Memory addresses leave the core through an ALU mode that forwards B unchanged. Load data enters the core over the A bus and through an ALU mode that forwards A unchanged.

A four-phase control sequencer steps each instruction through its cycles. Register-to-register operations and jumps take three cycles. Loads and stores take four cycles. The core talks to a single external word memory through a read strobe and a write strobe, with no wait states. Read data must be valid in the same cycle as the read strobe, and the core captures it on the closing edge.

Instructions are 32-bit words. Bits 31:28 hold the opcode, bits 27:24 the destination register, bits 23:20 the first source register (A), bits 19:16 the second source register (B), and bits 15:0 a signed immediate.

Top module: `onealu_cpu`

## Requirements
- R1: While reset is held, neither memory strobe is active. After reset, every register including the program counter (register 15) reads zero, so the first instruction read is from address 0.
- R2: Every instruction starts with two fetch cycles. In the first, the program counter is copied into the address register and no strobe is raised. In the second, the read strobe is raised at the program counter address, the word is latched as the current instruction, and register 15 is increased by 4.
- R3: Opcodes 0 to 4 (add, subtract, AND, OR, XOR of register A and register B) write the destination register in the third cycle and raise no strobe in that cycle.
- R4: Opcode 7 writes register A plus the sign-extended 16-bit immediate to the destination register in the third cycle.
- R5: Opcode 5 (load) takes four cycles. Cycle 3 loads register B into the address register. Cycle 4 raises the read strobe at that address and writes the returned word into the destination register.
- R6: Opcode 6 (store) takes four cycles. Cycle 3 loads register B into the address register. Cycle 4 raises the write strobe at that address with register A as write data.
- R7: Opcode 8 (jump) copies register B into register 15 in the third cycle, and the next fetch uses that address.
- R8: An ALU operation whose destination is register 15 redirects the next fetch to its result.
- R9: Opcodes 9 to 15 take three cycles and change no register and no memory location.
- R10: The read strobe and the write strobe are never active in the same cycle.
- R11: Reading register 15 as an operand during execution yields the address of the following instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address, driven from the address register |
| mem_rd_en | output | 1 | Read strobe; data is captured at the end of this cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data, taken from the A operand bus |
| mem_rdata | input | 32 | Read data, valid in the cycle of the read strobe |

## Verification
The second fetch cycle does two jobs at once: it reads the instruction word from memory and, through the same ALU, writes the incremented program counter back into the bank. That new value must then be visible to the instruction that was just fetched. The program provokes this collision in two ways. One instruction copies register 15 into a general register. Another instruction writes register 15 directly, competing with the fetch-time increment, and so does the jump. The bench judges the outcome on every clock by comparing the strobe, address and data pattern with a behavioural instruction model. It also inspects the stored results at the end of the run.

// File: rtl/onealu_pkg.sv
package onealu_pkg;

  localparam int WORD = 32;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_LOAD  = 4'd5,
    OP_STORE = 4'd6,
    OP_ADDI  = 4'd7,
    OP_JUMP  = 4'd8
  } opc_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_PASSA, FN_PASSB
  } alu_fn_e;

  typedef enum logic [1:0] {B_REG, B_IMM, B_STEP} bsel_e;

  typedef enum logic [1:0] {S_F0, S_F1, S_E0, S_E1} phase_e;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  rd;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [15:0] imm;
  } instr_t;

  typedef struct packed {
    logic    a_pc;    // port A reads program counter
    logic    b_pc;    // port B reads program counter
    logic    a_mem;   // A bus sourced from memory read data
    bsel_e   bsel;
    alu_fn_e fn;
    logic    rf_we;
    logic    w_pc;    // write port targets program counter
    logic    mar_we;
    logic    ir_we;
    logic    rd_en;
    logic    wr_en;
  } ctl_t;

  function automatic logic [WORD-1:0] alu_eval(alu_fn_e fn,
                                               logic [WORD-1:0] a,
                                               logic [WORD-1:0] b);
    logic [WORD-1:0] y;
    unique case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_PASSA: y = a;
      default:  y = b;
    endcase
    return y;
  endfunction

  function automatic logic [WORD-1:0] sext16(logic [15:0] v);
    return {{(WORD-16){v[15]}}, v};
  endfunction

  function automatic alu_fn_e op_to_fn(logic [3:0] op);
    alu_fn_e f;
    case (op)
      OP_SUB:  f = FN_SUB;
      OP_AND:  f = FN_AND;
      OP_OR:   f = FN_OR;
      OP_XOR:  f = FN_XOR;
      default: f = FN_ADD;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/onealu_regbank.sv
module onealu_regbank #(
  parameter int NREG   = 16,
  parameter int W      = 32,
  parameter int PC_IDX = 15,
  localparam int AW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  pc_o
);

  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
  assign pc_o    = regs_q[PC_IDX];

endmodule

// File: rtl/onealu_alu.sv
module onealu_alu
  import onealu_pkg::*;
#(
  parameter int W = WORD
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  assign y = alu_eval(fn, a, b);

endmodule

// File: rtl/onealu_seq.sv
module onealu_seq
  import onealu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  output phase_e     phase_o,
  output ctl_t       ctl_o
);

  phase_e ph_q, ph_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= S_F0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    ctl_o      = '0;
    ctl_o.bsel = B_REG;
    ctl_o.fn   = FN_PASSB;
    ph_d       = S_F0;
    unique case (ph_q)
      S_F0: begin
        ctl_o.b_pc   = 1'b1;
        ctl_o.mar_we = 1'b1;
        ph_d         = S_F1;
      end
      S_F1: begin
        ctl_o.rd_en = 1'b1;
        ctl_o.ir_we = 1'b1;
        ctl_o.a_pc  = 1'b1;
        ctl_o.bsel  = B_STEP;
        ctl_o.fn    = FN_ADD;
        ctl_o.rf_we = 1'b1;
        ctl_o.w_pc  = 1'b1;
        ph_d        = S_E0;
      end
      S_E0: begin
        case (op)
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
            ctl_o.fn    = op_to_fn(op);
            ctl_o.rf_we = 1'b1;
          end
          OP_ADDI: begin
            ctl_o.bsel  = B_IMM;
            ctl_o.fn    = FN_ADD;
            ctl_o.rf_we = 1'b1;
          end
          OP_LOAD, OP_STORE: begin
            ctl_o.mar_we = 1'b1;
            ph_d         = S_E1;
          end
          OP_JUMP: begin
            ctl_o.rf_we = 1'b1;
            ctl_o.w_pc  = 1'b1;
          end
          default: ;
        endcase
      end
      default: begin
        if (op == OP_LOAD) begin
          ctl_o.rd_en = 1'b1;
          ctl_o.a_mem = 1'b1;
          ctl_o.fn    = FN_PASSA;
          ctl_o.rf_we = 1'b1;
        end else begin
          ctl_o.wr_en = 1'b1;
        end
      end
    endcase
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/onealu_cpu.sv
module onealu_cpu
  import onealu_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int PC_IDX  = 15,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [WORD-1:0] mem_addr,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [WORD-1:0] mem_wdata,
  input  logic [WORD-1:0] mem_rdata
);

  localparam int AW = $clog2(NREG);

  ctl_t            ctl;
  phase_e          st_q;
  instr_t          ir_q;
  logic [WORD-1:0] mar_q;
  logic [WORD-1:0] ra_data, rb_data, abus, bbus, alu_y, pc_now;
  logic [AW-1:0]   ra_sel, rb_sel, w_sel;

  onealu_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (ir_q.op),
    .phase_o (st_q),
    .ctl_o   (ctl)
  );

  assign ra_sel = ctl.a_pc ? AW'(PC_IDX) : AW'(ir_q.ra);
  assign rb_sel = ctl.b_pc ? AW'(PC_IDX) : AW'(ir_q.rb);
  assign w_sel  = ctl.w_pc ? AW'(PC_IDX) : AW'(ir_q.rd);

  onealu_regbank #(.NREG(NREG), .W(WORD), .PC_IDX(PC_IDX)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (ra_sel),
    .rb_addr (rb_sel),
    .ra_data (ra_data),
    .rb_data (rb_data),
    .we      (ctl.rf_we),
    .waddr   (w_sel),
    .wdata   (alu_y),
    .pc_o    (pc_now)
  );

  assign abus = ctl.a_mem ? mem_rdata : ra_data;

  always_comb begin
    unique case (ctl.bsel)
      B_IMM:   bbus = sext16(ir_q.imm);
      B_STEP:  bbus = WORD'(PC_STEP);
      default: bbus = rb_data;
    endcase
  end

  onealu_alu #(.W(WORD)) u_alu (
    .fn (ctl.fn),
    .a  (abus),
    .b  (bbus),
    .y  (alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ctl.mar_we) mar_q <= alu_y;
      if (ctl.ir_we)  ir_q  <= mem_rdata;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd_en = ctl.rd_en;
  assign mem_wr_en = ctl.wr_en;
  assign mem_wdata = abus;

endmodule

// File: rtl/onealu_cpu_chk.sv
module onealu_cpu_chk
  import onealu_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input phase_e          st,
  input logic            rd,
  input logic            wr,
  input logic [WORD-1:0] addr,
  input logic [WORD-1:0] pc,
  input logic [WORD-1:0] ir
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rd && !wr);
    end
  end

  p_excl_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F0) |=> (rd && addr == $past(pc)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F1) |=> (pc == $past(pc) + WORD'(PC_STEP)));

  p_ir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_F1) |=> $stable(ir));

  p_mem_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_E1) |=> (st == S_F0));

  p_store_keeps_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pc == $past(pc)));

endmodule

bind onealu_cpu onealu_cpu_chk #(.PC_STEP(PC_STEP)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .st    (st_q),
  .rd    (mem_rd_en),
  .wr    (mem_wr_en),
  .addr  (mem_addr),
  .pc    (pc_now),
  .ir    (ir_q)
);

// File: tb/onealu_cpu_test.sv
`timescale 1ns/1ps
module onealu_cpu_test;

  typedef struct {
    bit          rd;
    bit          wr;
    logic [31:0] addr;
    logic [31:0] wd;
    string       req;
  } cyc_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd_en, mem_wr_en;

  logic [31:0] mem  [64];
  logic [31:0] mref [64];
  logic [31:0] mregs [16];
  cyc_t        q[$];
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  onealu_cpu uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;

  function automatic logic [31:0] enc(int op, int rd, int ra, int rb, int imm);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm[15:0]};
  endfunction

  task automatic put(int idx, logic [31:0] w);
    mem[idx]  = w;
    mref[idx] = w;
  endtask

  task automatic push(bit rd, bit wr, logic [31:0] a, logic [31:0] d, string r);
    cyc_t c;
    c.rd = rd; c.wr = wr; c.addr = a; c.wd = d; c.req = r;
    q.push_back(c);
  endtask

  // Behavioural instruction model: plans the bus pattern of one instruction
  task automatic plan_instr();
    logic [31:0] w, pcf, a, b, res;
    int op, rd, ra, rb;
    string tag;
    pcf = mregs[15];
    w   = mref[pcf[7:2]];
    mregs[15] = pcf + 32'd4;
    tag = (pcf == 0) ? "R1 first fetch" : "R2 fetch";
    push(0, 0, '0, '0, tag);
    push(1, 0, pcf, '0, tag);
    op = int'(w[31:28]); rd = int'(w[27:24]);
    ra = int'(w[23:20]); rb = int'(w[19:16]);
    a = mregs[ra]; b = mregs[rb];
    case (op)
      0, 1, 2, 3, 4, 7: begin
        case (op)
          0: res = a + b;
          1: res = a - b;
          2: res = a & b;
          3: res = a | b;
          4: res = a ^ b;
          default: res = a + {{16{w[15]}}, w[15:0]};
        endcase
        push(0, 0, '0, '0, (rd == 15) ? "R8 pc dest" : (op == 7 ? "R4 addi" : "R3 alu"));
        mregs[rd] = res;
      end
      5: begin
        push(0, 0, '0, '0, "R5 load addr");
        push(1, 0, b, '0, "R5 load read");
        mregs[rd] = mref[b[7:2]];
      end
      6: begin
        push(0, 0, '0, '0, "R6 store addr");
        push(0, 1, b, a, "R6 store write");
        mref[b[7:2]] = a;
      end
      8: begin
        push(0, 0, '0, '0, "R7 jump");
        mregs[15] = b;
      end
      default: push(0, 0, '0, '0, "R9 unused opcode");
    endcase
  endtask

  task automatic check_cycle(cyc_t e);
    bit bad;
    checks++;
    bad = (mem_rd_en !== e.rd) || (mem_wr_en !== e.wr);
    if ((e.rd || e.wr) && mem_addr !== e.addr) bad = 1;
    if (e.wr && mem_wdata !== e.wd) bad = 1;
    if (mem_rd_en && mem_wr_en) bad = 1; // R10
    if (bad) begin
      errors++;
      $display("FAIL %s: rd=%0b wr=%0b addr=%h wd=%h expected rd=%0b wr=%0b addr=%h wd=%h",
               e.req, mem_rd_en, mem_wr_en, mem_addr, mem_wdata, e.rd, e.wr, e.addr, e.wd);
    end
  endtask

  task automatic check_word(int idx, logic [31:0] exp, string r);
    checks++;
    if (mem[idx] !== exp) begin
      errors++;
      $display("FAIL %s: mem[%0d]=%h expected %h", r, idx, mem[idx], exp);
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; mref[i] = '0; end
    for (int i = 0; i < 16; i++) mregs[i] = '0;
    put(0,  enc(7, 1, 0, 0, 'h00C0));
    put(1,  enc(7, 2, 0, 0, 7));
    put(2,  enc(7, 3, 0, 0, 'hFFFD));
    put(3,  enc(0, 4, 2, 3, 0));
    put(4,  enc(1, 5, 2, 3, 0));
    put(5,  enc(2, 6, 2, 3, 0));
    put(6,  enc(3, 7, 2, 3, 0));
    put(7,  enc(4, 8, 2, 3, 0));
    put(8,  enc(6, 0, 4, 1, 0));
    put(9,  enc(5, 9, 0, 1, 0));
    put(10, enc(7, 10, 1, 0, 4));
    put(11, enc(6, 0, 9, 10, 0));
    put(12, enc(9, 2, 2, 2, 1));
    put(13, enc(0, 11, 15, 0, 0));
    put(14, enc(7, 12, 0, 0, 'h0044));
    put(15, enc(8, 0, 0, 12, 0));
    put(16, enc(7, 2, 0, 0, 'h55));
    put(17, enc(7, 13, 0, 0, 'h0050));
    put(18, enc(0, 15, 13, 0, 0));
    put(19, enc(7, 2, 0, 0, 'h66));
    put(20, enc(7, 14, 1, 0, 8));  put(21, enc(6, 0, 2, 14, 0));
    put(22, enc(7, 14, 1, 0, 12)); put(23, enc(6, 0, 5, 14, 0));
    put(24, enc(7, 14, 1, 0, 16)); put(25, enc(6, 0, 6, 14, 0));
    put(26, enc(7, 14, 1, 0, 20)); put(27, enc(6, 0, 7, 14, 0));
    put(28, enc(7, 14, 1, 0, 24)); put(29, enc(6, 0, 8, 14, 0));
    put(30, enc(7, 14, 1, 0, 28)); put(31, enc(6, 0, 11, 14, 0));
    put(32, enc(7, 14, 1, 0, 32)); put(33, enc(6, 0, 3, 14, 0));
    put(34, enc(7, 12, 15, 0, 'hFFFC));
    put(35, enc(8, 0, 0, 12, 0));

    // R1: strobes quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (mem_rd_en !== 1'b0 || mem_wr_en !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: rd=%0b wr=%0b expected rd=0 wr=0", mem_rd_en, mem_wr_en);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 420; c++) begin
      cyc_t e;
      #1;
      if (q.size() == 0) plan_instr();
      e = q.pop_front();
      check_cycle(e);
      @(negedge clk);
    end

    check_word(48, 32'h0000_0004, "R6 store");
    check_word(49, 32'h0000_0004, "R5 load");
    check_word(50, 32'h0000_0007, "R9 unused opcode / R7 R8 skipped words");
    check_word(51, 32'h0000_000A, "R3 sub");
    check_word(52, 32'h0000_0005, "R3 and");
    check_word(53, 32'hFFFF_FFFF, "R3 or");
    check_word(54, 32'hFFFF_FFFA, "R3 xor");
    check_word(55, 32'h0000_0038, "R11 pc operand");
    check_word(56, 32'hFFFF_FFFD, "R4 sign extend");
    for (int i = 0; i < 64; i++) begin
      if (mem[i] !== mref[i]) check_word(i, mref[i], "R6 memory image");
    end
    checks++;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule